// File: doc/BRIEF.md
# Byte-Addressed Serial Memory Target with Persistent Read Pointer

This block is an I2C target that exposes a small internal byte memory (256 locations by default) to a bus controller. SCL and SDA are sampled on the system clock through two-flop synchronizers. SDA is modelled as open drain: the block has an input, a drive-enable and a data output that is always low, so the bus is pulled low whenever the enable is set. A separate preload port writes the memory directly on the system clock.

A single pointer register decides which location any read returns. It is loaded by the first byte of a write transaction. It steps by one whenever a byte is stored and whenever a byte is fetched for transmission. After it reaches the top location it wraps to zero. A read with no address phase therefore continues from the location after the last one touched. A random read is a write header and an address byte followed by a repeated START and a read header. Either kind of read becomes a sequential read while the controller keeps acknowledging.

The controller is a ten-state machine. The states are ST_IDLE, ST_HDR, ST_HDR_ACK, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WDATA_ACK, ST_TX, ST_TX_ACK and ST_IGNORE. A START from any state leads to ST_HDR, and a STOP from any state leads to ST_IDLE. The other transitions happen on a synchronized SCL falling edge:
- ST_HDR goes to ST_HDR_ACK on an address match, or to ST_IGNORE on a mismatch.
- ST_HDR_ACK goes to ST_TX for a read or to ST_ADDR for a write.
- ST_ADDR goes to ST_ADDR_ACK, which goes to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK, which goes to ST_IGNORE.
- ST_TX goes to ST_TX_ACK after eight bits.
- ST_TX_ACK goes back to ST_TX on a controller ACK, or to ST_IGNORE on a NACK.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the SDA drive enable is low and the read pointer is 0, so the first read with no address phase returns location 0.
- R2: A header whose upper seven bits equal the TGT_ADDR parameter (default 7'b1010000) and whose bit 0 (R/W) is 1 is acknowledged. The block then sends one data byte, MSB first.
- R3: Any read or write of location N leaves the pointer at N+1, so a following read with no address phase returns location N+1.
- R4: The pointer wraps from 255 to 0, and a sequential read carries on with valid data across the wrap.
- R5: For a random read, the block acknowledges a write header (R/W = 0) and the address byte that follows. After a repeated START and a read header it acknowledges and sends the byte at that address.
- R6: A controller ACK (SDA low in the ninth clock) after a data byte makes the block send the next location. A NACK followed by STOP ends the read, and the pointer stays one past the last byte sent.
- R7: A header with a different address gets no ACK. The block then never drives SDA until the next START or STOP, and its pointer is not changed.
- R8: In a write transaction the first byte loads the pointer. A second byte is acknowledged, stored at that address, and advances the pointer by one. A third byte is not acknowledged and not stored.
- R9: A START or repeated START in the middle of a byte restarts header reception, and the partial byte has no effect on the pointer.
- R10: The block changes its SDA drive only while SCL is low. It releases SDA during the controller's ACK/NACK clock after each byte it sends.
- R11: A write on the preload port stores the byte at the given location, and bus reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_out | output | 1 | Data value driven when enabled (always 0) |
| sda_drive_en | output | 1 | Pulls SDA low when 1 |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | AW | Preload location |
| pl_data | input | 8 | Preload byte |

## Verification
The hardest case to reach from the ports is pointer behaviour at the edges of a transaction. These are the wrap from 255 to 0 inside a sequential read, the final NACKed byte that must still advance the pointer, and a repeated START that cuts an address byte after four bits. The directed tests reach them by setting the pointer with a random read at 253 and pulling five bytes. They then check the next unaddressed read. They also abandon a write after four address bits, then read back and compare against a model pointer kept in the bench. A monitor counts every change of the drive enable that happens while the bench holds SCL high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_t;

endpackage

// File: rtl/i2c_sync_edge.sv
module i2c_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            last  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~last;
    assign fall = ~lvl & last;

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_det,
    output logic stop_det
);
    // data line moving while clock line is high marks a bus condition
    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [DW-1:0] pl_data,
    input  logic          bw_en,
    input  logic [AW-1:0] bw_addr,
    input  logic [DW-1:0] bw_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // preload port wins if both strike in one cycle
    always_ff @(posedge clk) begin
        if (pl_we) begin
            mem[pl_addr] <= pl_data;
        end else if (bw_en) begin
            mem[bw_addr] <= bw_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'b1010000,
    parameter int         AW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    tgt_state_t        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic              rw_q, ack_seen;
    logic              rx_full, hdr_match, bus_evt, load_tx, rx_state;

    assign rx_full   = (bit_cnt == CNT_W'(BYTE_W));
    assign hdr_match = (rx_sh[BYTE_W-1:1] == TGT_ADDR);
    assign bus_evt   = start_det | stop_det;
    assign rx_state  = (state inside {ST_HDR, ST_ADDR, ST_WDATA});
    assign load_tx   = !bus_evt && scl_fall &&
                       ((state == ST_HDR_ACK && rw_q) || (state == ST_TX_ACK && ack_seen));
    assign wr_en     = !bus_evt && scl_fall && rx_full && (state == ST_WDATA);
    assign wr_data   = rx_sh;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      state_nx = ST_IDLE;
            ST_HDR:       if (scl_fall && rx_full) state_nx = hdr_match ? ST_HDR_ACK : ST_IGNORE;
            ST_HDR_ACK:   if (scl_fall) state_nx = rw_q ? ST_TX : ST_ADDR;
            ST_ADDR:      if (scl_fall && rx_full) state_nx = ST_ADDR_ACK;
            ST_ADDR_ACK:  if (scl_fall) state_nx = ST_WDATA;
            ST_WDATA:     if (scl_fall && rx_full) state_nx = ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall) state_nx = ST_IGNORE;
            ST_TX:        if (scl_fall && bit_cnt == CNT_W'(BYTE_W - 1)) state_nx = ST_TX_ACK;
            ST_TX_ACK:    if (scl_fall) state_nx = ack_seen ? ST_TX : ST_IGNORE;
            ST_IGNORE:    state_nx = ST_IGNORE;
            default:      state_nx = ST_IDLE;
        endcase
        if (start_det) begin
            state_nx = ST_HDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // shift registers, bit counter and read pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rw_q     <= 1'b0;
            ack_seen <= 1'b0;
            ptr      <= '0;
        end else if (bus_evt) begin
            bit_cnt <= '0;
        end else begin
            if (rx_state && scl_rise && !rx_full) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall) begin
                case (state)
                    ST_HDR: begin
                        if (rx_full) begin
                            rw_q    <= rx_sh[0];
                            bit_cnt <= '0;
                        end
                    end
                    ST_ADDR: begin
                        if (rx_full) begin
                            ptr     <= rx_sh[AW-1:0];
                            bit_cnt <= '0;
                        end
                    end
                    ST_WDATA: begin
                        if (rx_full) begin
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                        end
                    end
                    ST_TX: begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                        bit_cnt <= (bit_cnt == CNT_W'(BYTE_W - 1)) ? '0 : bit_cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
            if (load_tx) begin
                tx_sh   <= rd_data;
                ptr     <= ptr + 1'b1;
                bit_cnt <= '0;
            end
            if (state == ST_TX_ACK && scl_rise) begin
                ack_seen <= !sda_lvl;
            end
        end
    end

    // line drive
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_HDR_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_TX:                                 sda_oe = !tx_sh[BYTE_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    AST_START_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_HDR && bit_cnt == '0)); // R9
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe)); // R9
    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl); // R10
    AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !$past(bus_evt)) |-> !scl_lvl); // R10
    AST_PTR_STEP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_tx |=> (ptr == $past(ptr) + 1'b1)); // R3
    AST_NO_ACK_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && scl_fall && rx_full && !hdr_match && !bus_evt) |=> !sda_oe); // R7
    AST_IGNORE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && $past(state) == ST_IGNORE) |-> $stable(ptr)); // R7

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'b1010000,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_out,
    output logic              sda_drive_en,
    input  logic              pl_we,
    input  logic [AW-1:0]     pl_addr,
    input  logic [BYTE_W-1:0] pl_data
);
    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [LINES-1:0]  raw, lvl, rise, fall;
    logic              start_det, stop_det;
    logic [AW-1:0]     ptr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, rd_data;

    assign raw[L_SCL] = scl_in;
    assign raw[L_SDA] = sda_in;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_sync
            i2c_sync_edge #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (raw[g]),
                .lvl      (lvl[g]),
                .rise     (rise[g]),
                .fall     (fall[g])
            );
        end
    endgenerate

    i2c_cond_detect u_cond (
        .scl_lvl   (lvl[L_SCL]),
        .sda_rise  (rise[L_SDA]),
        .sda_fall  (fall[L_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_mem_array #(
        .AW (AW),
        .DW (BYTE_W)
    ) u_mem (
        .clk     (clk),
        .pl_we   (pl_we),
        .pl_addr (pl_addr),
        .pl_data (pl_data),
        .bw_en   (wr_en),
        .bw_addr (ptr),
        .bw_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    i2c_tgt_fsm #(
        .TGT_ADDR (TGT_ADDR),
        .AW       (AW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (lvl[L_SCL]),
        .sda_lvl   (lvl[L_SDA]),
        .scl_rise  (rise[L_SCL]),
        .scl_fall  (fall[L_SCL]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_drive_en)
    );

    assign sda_out = 1'b0;

endmodule

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;

    localparam int         H    = 20;
    localparam logic [6:0] TADR = 7'b1010000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pl_we = 1'b0;
    logic [7:0] pl_addr = '0;
    logic [7:0] pl_data = '0;
    logic       sda_out, sda_drive_en;
    wire        sda_bus = sda_m & ~sda_drive_en;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    int oe_cycles = 0;
    logic oe_prev = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] mctr = '0;

    always #5 clk = ~clk;

    i2c_mem_target i_i2c_mem_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .sda_out      (sda_out),
        .sda_drive_en (sda_drive_en),
        .pl_we        (pl_we),
        .pl_addr      (pl_addr),
        .pl_data      (pl_data)
    );

    // line-drive monitor: R10
    always @(posedge clk) begin
        if (rst_n && scl_m && (sda_drive_en != oe_prev)) viol++;
        if (sda_drive_en) oe_cycles++;
        oe_prev <= sda_drive_en;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(H/2);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        b = sda_bus;  tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v = {v[6:0], b};
        end
        sda_m = !give_ack; tick(H/2);
        scl_m = 1'b1;      tick(H/2);
        chk("R10 line released in controller ack clock", sda_drive_en, 0);
        tick(H/2);
        scl_m = 1'b0;      tick(H/2);
    endtask

    // read n bytes from wherever the pointer stands
    task automatic do_read(input int n, input string req);
        logic       a;
        logic [7:0] d;
        bus_start();
        send_byte({TADR, 1'b1}, a);
        chk({req, " R2 read header ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(req, d, exp_mem[mctr]);
            mctr = mctr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic set_addr(input logic [7:0] ad, input string req);
        logic a;
        bus_start();
        send_byte({TADR, 1'b0}, a);
        chk({req, " R5 write header ack"}, a, 1);
        send_byte(ad, a);
        chk({req, " R5 address ack"}, a, 1);
        mctr = ad;
    endtask

    task automatic rand_read(input logic [7:0] ad, input int n, input string req);
        set_addr(ad, req);
        do_read(n, req);
    endtask

    task automatic write_one(input logic [7:0] ad, input logic [7:0] dv);
        logic a;
        set_addr(ad, "R8");
        send_byte(dv, a);
        chk("R8 data ack", a, 1);
        bus_stop();
        exp_mem[ad] = dv;
        mctr = ad + 8'd1;
    endtask

    task automatic preload(input logic [7:0] ad, input logic [7:0] dv);
        pl_addr = ad; pl_data = dv; pl_we = 1'b1;
        tick(1);
        pl_we = 1'b0;
        exp_mem[ad] = dv;
    endtask

    task automatic t_reset();
        chk("R1 drive enable low after reset", sda_drive_en, 0);
        do_read(1, "R1 first read from location 0");
    endtask

    task automatic t_current();
        do_read(1, "R3 current read N+1");
        do_read(1, "R3 current read N+2");
    endtask

    task automatic t_random();
        rand_read(8'h40, 1, "R5 random read");
        do_read(1, "R3 read after random");
    endtask

    task automatic t_seq_wrap();
        rand_read(8'hFD, 5, "R4 R6 sequential across wrap");
        do_read(1, "R6 pointer past last nacked byte");
        do_read(3, "R6 sequential from current read");
    endtask

    task automatic t_write();
        logic a;
        write_one(8'h10, 8'h3C);
        rand_read(8'h10, 1, "R8 stored byte");
        write_one(8'h20, 8'h99);
        do_read(1, "R8 pointer after write");
        set_addr(8'h30, "R8");
        send_byte(8'h11, a);
        chk("R8 first data ack", a, 1);
        send_byte(8'h22, a);
        chk("R8 third byte not acked", a, 0);
        bus_stop();
        exp_mem[8'h30] = 8'h11;
        rand_read(8'h31, 1, "R8 third byte not stored");
        rand_read(8'h30, 1, "R8 second byte stored");
    endtask

    task automatic t_mismatch();
        logic a;
        int   snap;
        bus_start();
        send_byte({TADR ^ 7'h01, 1'b1}, a);
        chk("R7 foreign header not acked", a, 0);
        snap = oe_cycles;
        send_byte(8'h00, a);
        send_byte(8'h5A, a);
        chk("R7 no drive while ignoring", oe_cycles - snap, 0);
        bus_stop();
        do_read(1, "R7 pointer unchanged");
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte({TADR, 1'b0}, a);
        chk("R9 write header ack", a, 1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        do_read(2, "R9 repeated start mid byte");
    endtask

    task automatic t_preload();
        preload(8'h80, 8'hC7);
        rand_read(8'h80, 1, "R11 runtime preload");
        preload(8'hFF, 8'h0E);
        rand_read(8'hFF, 2, "R11 R4 preload at top");
    endtask

    initial begin
        tick(5);
        chk("R1 drive enable low in reset", sda_drive_en, 0);
        rst_n = 1'b1;
        tick(5);
        for (int i = 0; i < 256; i++) preload(8'(i), 8'((i * 37 + 11) & 8'hFF));
        tick(10);
        t_reset();
        t_current();
        t_random();
        t_seq_wrap();
        t_write();
        t_mismatch();
        t_restart();
        t_preload();
        chk("R10 drive changed while SCL high", viol, 0);
        tick(20);
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired R1 actual 0 expected 1");
        summary();
    end

endmodule